// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host-side master for a three-wire serial analog-to-digital converter. It lowers chip select to begin a conversion, generates exactly sixteen serial-clock cycles from the system clock through a programmable half-period divider, and shifts in one data bit at every falling serial-clock edge. Once the frame is complete it raises chip select, removes the four leading zeros and any trailing zeros that the selected resolution implies, and presents the sample right-aligned behind a valid/ready handshake. A frame is started by a single start pulse, or automatically when the continuous-mode input is held high. Between frames a programmable quiet interval keeps chip select high before the next conversion may begin.

The sequencer has five states. IDLE waits for a launch. SETUP holds chip select low with the clock high for one half period. CLK_LO and CLK_HI alternate the two clock phases. QUIET counts down the quiet interval. The transitions are as follows. IDLE goes to SETUP on launch, which needs a start pulse or continuous mode while the output slot is free. SETUP goes to CLK_LO on a half-period tick, and that tick makes falling edge 1. CLK_LO goes to CLK_HI on a tick until sixteen falling edges have been produced. CLK_HI goes to CLK_LO on a tick, which makes the next falling edge. CLK_LO goes to QUIET on the tick after the sixteenth falling edge, where chip select rises and the result is published. QUIET goes back to IDLE when its counter reaches zero.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and after its release, `adc_cs_n` is 1, `adc_sclk` is 1 and `res_valid` is 0.
- R2: `adc_sclk` is high whenever `adc_cs_n` is high, and every frame produces exactly 16 falling edges of `adc_sclk` while `adc_cs_n` is low.
- R3: Each serial-clock half period lasts `cfg_div`+1 system cycles. The first falling edge comes one half period after `adc_cs_n` falls, and `adc_cs_n` stays low for exactly 32×(`cfg_div`+1) cycles.
- R4: `adc_sdata` is sampled at each falling-edge instant. The first bit received is the most significant bit of the 16-bit frame.
- R5: `cfg_res` selects the resolution. Code 0 (and reserved code 3) gives 12 bits, taken from frame bits 5 to 16. Code 1 gives 10 bits from frame bits 5 to 14, and the last 2 bits are discarded. Code 2 gives 8 bits from frame bits 5 to 12, and the last 4 bits are discarded. The result is right-aligned on `res_data` and its upper bits are zero.
- R6: `cfg_res` and `cfg_div` are captured when a frame launches. Changing them during the frame has no effect on that frame.
- R7: `res_frame_err` is returned with each result and is 1 exactly when any of the first four received bits was 1.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data` and `res_frame_err` stay unchanged. A cycle in which both are 1 clears `res_valid`.
- R9: After `adc_cs_n` rises, it stays high for at least `cfg_quiet`+1 cycles. When frames relaunch back to back, it stays high for exactly `cfg_quiet`+2 cycles.
- R10: A frame launches only from IDLE, when `start` or `cfg_cont` is 1 and the output slot is free. The slot is free when `res_valid` is 0 or is being accepted in the same cycle. A `start` pulse at any other time is ignored.
- R11: With `cfg_cont` held at 1, frames relaunch after each quiet interval without any start pulse. Clearing `cfg_cont` stops relaunching once the current frame has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Serial-clock half period minus one, in system cycles |
| cfg_quiet | input | QUIET_W | Quiet interval setting |
| cfg_res | input | 2 | Resolution code: 0 = 12 bits, 1 = 10 bits, 2 = 8 bits, 3 = 12 bits |
| cfg_cont | input | 1 | Continuous sampling enable |
| start | input | 1 | Single-frame request pulse |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdata | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 12 | Right-aligned sample |
| res_frame_err | output | 1 | A leading bit was 1 |

## Verification
The two functions that can meet in one cycle are the consumer accepting a held result and the sequencer launching the next frame, because launch treats a slot that is being accepted as free. The bench keeps a result waiting with ready low and confirms that a start pulse is ignored. It then raises start and ready in the same cycle and expects the old result to clear while chip select falls for a new frame, whose data is checked in turn. Continuous mode with ready held high produces the same overlap on every frame, and there the quiet gap is judged to be exactly `cfg_quiet`+2 cycles.

// File: rtl/afr_pkg.sv
package afr_pkg;

    localparam int FRAME_BITS = 16;
    localparam int LEAD_BITS  = 4;
    localparam int RES_W      = FRAME_BITS - LEAD_BITS;
    localparam int FALL_CNT_W = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_QUIET
    } afr_state_t;

    typedef enum logic [1:0] {
        RES_12  = 2'd0,
        RES_10  = 2'd1,
        RES_8   = 2'd2,
        RES_RSV = 2'd3
    } afr_res_t;

endpackage

// File: rtl/afr_halfbit_timer.sv
module afr_halfbit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;

    // While stopped, the divider value is captured so a running frame keeps its rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= '0;
        end else if (!run) begin
            cnt   <= cfg_div;
            div_q <= cfg_div;
        end else if (cnt == '0) begin
            cnt   <= div_q;
        end else begin
            cnt   <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

    // R3: a running phase never outlasts the captured half period
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && !$past(tick) |-> cnt < div_q);

endmodule

// File: rtl/afr_capture.sv
module afr_capture
    import afr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdata,
    input  afr_res_t         res_sel,
    output logic [RES_W-1:0] data,
    output logic             frame_err
);

    logic [FRAME_BITS-1:0] sh;
    logic [2:0]            trail;
    logic [RES_W-1:0]      body;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (shift_en) begin
            sh <= {sh[FRAME_BITS-2:0], sdata};
        end
    end

    always_comb begin
        unique case (res_sel)
            RES_10:  trail = 3'd2;
            RES_8:   trail = 3'd4;
            default: trail = 3'd0;
        endcase
    end

    assign body      = sh[RES_W-1:0];
    assign data      = body >> trail;
    assign frame_err = |sh[FRAME_BITS-1:RES_W];

endmodule

// File: rtl/afr_result_slot.sv
module afr_result_slot #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             publish,
    input  logic [RES_W-1:0] pub_data,
    input  logic             pub_err,
    input  logic             res_ready,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             res_err,
    output logic             slot_free
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_err   <= 1'b0;
        end else if (publish) begin
            res_valid <= 1'b1;
            res_data  <= pub_data;
            res_err   <= pub_err;
        end else if (res_valid && res_ready) begin
            res_valid <= 1'b0;
        end
    end

    assign slot_free = !res_valid || res_ready;

    // R8: a waiting result is held untouched
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_err));

    // R10: a new result never lands on an unaccepted one
    p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        publish |-> !res_valid);

endmodule

// File: rtl/afr_sequencer.sv
module afr_sequencer
    import afr_pkg::*;
#(
    parameter int QUIET_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cfg_cont,
    input  logic [1:0]         cfg_res,
    input  logic [QUIET_W-1:0] cfg_quiet,
    input  logic               tick,
    input  logic               slot_free,
    output logic               cs_n,
    output logic               sclk,
    output logic               run,
    output logic               shift_en,
    output logic               publish,
    output afr_res_t           res_sel
);

    localparam logic [FALL_CNT_W-1:0] LAST_FALL = FALL_CNT_W'(FRAME_BITS);

    afr_state_t              state;
    afr_state_t              nxt;
    logic [FALL_CNT_W-1:0]   falls;
    logic [QUIET_W-1:0]      q_cnt;
    logic                    launch;
    logic                    last_fall;

    assign launch    = (state == ST_IDLE) && (start || cfg_cont) && slot_free;
    assign last_fall = (falls == LAST_FALL);
    assign run       = (state == ST_SETUP) || (state == ST_CLK_LO) || (state == ST_CLK_HI);
    assign shift_en  = tick && ((state == ST_SETUP) || (state == ST_CLK_HI));
    assign publish   = tick && (state == ST_CLK_LO) && last_fall;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (launch) nxt = ST_SETUP;
            ST_SETUP:  if (tick) nxt = ST_CLK_LO;
            ST_CLK_LO: if (tick) nxt = last_fall ? ST_QUIET : ST_CLK_HI;
            ST_CLK_HI: if (tick) nxt = ST_CLK_LO;
            ST_QUIET:  if (q_cnt == '0) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Pin and counter outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n    <= 1'b1;
            sclk    <= 1'b1;
            falls   <= '0;
            q_cnt   <= '0;
            res_sel <= RES_12;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        cs_n    <= 1'b0;
                        sclk    <= 1'b1;
                        falls   <= '0;
                        res_sel <= afr_res_t'(cfg_res);
                    end
                end
                ST_SETUP, ST_CLK_HI: begin
                    if (tick) begin
                        sclk  <= 1'b0;
                        falls <= falls + 1'b1;
                    end
                end
                ST_CLK_LO: begin
                    if (tick) begin
                        sclk <= 1'b1;
                        if (last_fall) begin
                            cs_n  <= 1'b1;
                            q_cnt <= cfg_quiet;
                        end
                    end
                end
                ST_QUIET: begin
                    if (q_cnt != '0) q_cnt <= q_cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Checker state for the quiet-gap property
    logic [QUIET_W:0]   hi_cyc;
    logic [QUIET_W-1:0] q_min;
    logic               seen_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cyc   <= '0;
            q_min    <= '0;
            seen_end <= 1'b0;
        end else begin
            if (!cs_n)            hi_cyc <= '0;
            else if (hi_cyc != '1) hi_cyc <= hi_cyc + 1'b1;
            if (publish) begin
                q_min    <= cfg_quiet;
                seen_end <= 1'b1;
            end
        end
    end

    // R2: the clock rests high whenever chip select is inactive
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R2: never more than sixteen falling edges in a frame
    p_fall_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        falls <= LAST_FALL);

    // R9: chip select stays high for the quiet interval
    p_quiet_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) && seen_end |-> hi_cyc >= ({1'b0, q_min} + 1'b1));

    // R10: a frame begins only on a request with a free slot
    p_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(slot_free) && $past(start || cfg_cont));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import afr_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int QUIET_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [QUIET_W-1:0] cfg_quiet,
    input  logic [1:0]         cfg_res,
    input  logic               cfg_cont,
    input  logic               start,
    output logic               adc_cs_n,
    output logic               adc_sclk,
    input  logic               adc_sdata,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [RES_W-1:0]   res_data,
    output logic               res_frame_err
);

    logic             tick;
    logic             run;
    logic             shift_en;
    logic             publish;
    logic             slot_free;
    afr_res_t         res_sel;
    logic [RES_W-1:0] cap_data;
    logic             cap_err;

    afr_sequencer #(
        .QUIET_W (QUIET_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_cont  (cfg_cont),
        .cfg_res   (cfg_res),
        .cfg_quiet (cfg_quiet),
        .tick      (tick),
        .slot_free (slot_free),
        .cs_n      (adc_cs_n),
        .sclk      (adc_sclk),
        .run       (run),
        .shift_en  (shift_en),
        .publish   (publish),
        .res_sel   (res_sel)
    );

    afr_halfbit_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cfg_div (cfg_div),
        .tick    (tick)
    );

    afr_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .sdata     (adc_sdata),
        .res_sel   (res_sel),
        .data      (cap_data),
        .frame_err (cap_err)
    );

    afr_result_slot #(
        .RES_W (RES_W)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .publish   (publish),
        .pub_data  (cap_data),
        .pub_err   (cap_err),
        .res_ready (res_ready),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_err   (res_frame_err),
        .slot_free (slot_free)
    );

endmodule

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic [7:0]  cfg_quiet = 8'd0;
    logic [1:0]  cfg_res = 2'd0;
    logic        cfg_cont = 1'b0;
    logic        start = 1'b0;
    logic        res_ready = 1'b0;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        adc_sdata;
    logic        res_valid;
    logic [11:0] res_data;
    logic        res_frame_err;

    always #4 clk = ~clk;

    adc_frame_reader dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_div       (cfg_div),
        .cfg_quiet     (cfg_quiet),
        .cfg_res       (cfg_res),
        .cfg_cont      (cfg_cont),
        .start         (start),
        .adc_cs_n      (adc_cs_n),
        .adc_sclk      (adc_sclk),
        .adc_sdata     (adc_sdata),
        .res_valid     (res_valid),
        .res_ready     (res_ready),
        .res_data      (res_data),
        .res_frame_err (res_frame_err)
    );

    // Behavioural converter: bit 15 of the word is on the line when chip select falls
    logic [15:0] words [64];
    int          exp_d [64];
    int          exp_e [64];
    int          fno = 0;
    int          idx = 0;
    int          last_falls = 0;

    always @(negedge adc_sclk or posedge adc_cs_n) begin
        if (adc_cs_n) begin
            if (idx != 0) begin
                last_falls = idx;
                fno = fno + 1;
            end
            idx = 0;
        end else begin
            idx = idx + 1;
        end
    end

    assign adc_sdata = (!adc_cs_n && idx < 16) ? words[fno % 64][15 - idx] : 1'b0;

    // Pin monitor
    int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
    bit idle_bad = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            lo_run = 0; hi_run = 0; last_lo = 0; last_hi = 0; idle_bad = 1'b0;
        end else if (adc_cs_n) begin
            hi_run = hi_run + 1;
            if (lo_run != 0) begin last_lo = lo_run; lo_run = 0; end
            if (!adc_sclk) idle_bad = 1'b1;
        end else begin
            lo_run = lo_run + 1;
            if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int fi = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] make_word(logic [3:0] lead, logic [11:0] d, logic [3:0] tr, logic [1:0] r);
        case (r)
            2'd1:    return {lead, d[9:0], tr[1:0]};
            2'd2:    return {lead, d[7:0], tr};
            default: return {lead, d};
        endcase
    endfunction

    function automatic int ref_data(logic [11:0] d, logic [1:0] r);
        case (r)
            2'd1:    return int'(d[9:0]);
            2'd2:    return int'(d[7:0]);
            default: return int'(d);
        endcase
    endfunction

    task automatic prep(input int i, input logic [1:0] r, input logic [3:0] lead, input logic [11:0] d, input logic [3:0] tr);
        words[i % 64] = make_word(lead, d, tr, r);
        exp_d[i % 64] = ref_data(d, r);
        exp_e[i % 64] = (lead != 4'd0) ? 1 : 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        int n = 0;
        while (!res_valid && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!res_valid) chk(1'b0, req, "result timeout", 0, 1);
    endtask

    task automatic accept();
        @(negedge clk) res_ready = 1'b1;
        @(negedge clk) res_ready = 1'b0;
        chk(res_valid == 1'b0, "R8", "valid after accept", int'(res_valid), 0);
    endtask

    task automatic check_result(input int i, input string req);
        chk(int'(res_data) == exp_d[i % 64], req, "data", int'(res_data), exp_d[i % 64]);
        chk(int'(res_frame_err) == exp_e[i % 64], "R7", "frame_err", int'(res_frame_err), exp_e[i % 64]);
    endtask

    // One single-shot frame with full checks; the result stays unaccepted on return
    task automatic do_frame(input logic [1:0] r, input int div, input int q, input logic [3:0] lead,
                            input logic [11:0] d, input logic [3:0] tr, input string req);
        @(negedge clk);
        cfg_res = r; cfg_div = 8'(div); cfg_quiet = 8'(q);
        prep(fi, r, lead, d, tr);
        pulse_start();
        wait_valid(req);
        check_result(fi, req);
        @(negedge clk);
        chk(last_falls == 16, "R2", "falling edges", last_falls, 16);
        chk(last_lo == 32 * (div + 1), "R3", "cs low cycles", last_lo, 32 * (div + 1));
        fi++;
    endtask

    task automatic main_seq();
        void'($urandom(32'd2718));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1 && adc_sclk == 1'b1 && res_valid == 1'b0, "R1", "pins in reset",
            int'({adc_cs_n, adc_sclk, res_valid}), 6);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1 && adc_sclk == 1'b1 && res_valid == 1'b0, "R1", "pins after reset",
            int'({adc_cs_n, adc_sclk, res_valid}), 6);

        // R4 / R5: each resolution, with ones in the trailing positions
        do_frame(2'd0, 0, 2, 4'h0, 12'hA5C, 4'h0, "R4"); accept(); repeat (8) @(negedge clk);
        do_frame(2'd1, 1, 1, 4'h0, 12'h2B7, 4'hF, "R5"); accept(); repeat (8) @(negedge clk);
        do_frame(2'd2, 2, 0, 4'h0, 12'h096, 4'hF, "R5"); accept(); repeat (8) @(negedge clk);
        do_frame(2'd3, 0, 0, 4'h0, 12'hFFF, 4'h0, "R5"); accept(); repeat (8) @(negedge clk);

        // R7: leading ones flag the frame
        do_frame(2'd0, 0, 1, 4'h8, 12'h123, 4'h0, "R7"); accept(); repeat (8) @(negedge clk);
        do_frame(2'd2, 1, 1, 4'h1, 12'h0E1, 4'h5, "R7"); accept(); repeat (8) @(negedge clk);

        // R6: configuration change in mid-frame
        @(negedge clk);
        cfg_res = 2'd0; cfg_div = 8'd1; cfg_quiet = 8'd2;
        prep(fi, 2'd0, 4'h0, 12'hC3A, 4'h0);
        pulse_start();
        repeat (10) @(negedge clk);
        cfg_res = 2'd2; cfg_div = 8'd5;
        wait_valid("R6");
        check_result(fi, "R6");
        @(negedge clk);
        chk(last_lo == 64, "R6", "cs low cycles with captured divider", last_lo, 64);
        fi++;
        accept();
        repeat (8) @(negedge clk);

        // R10: a start pulse in mid-frame and one during the quiet interval are ignored
        do_frame(2'd0, 0, 20, 4'h0, 12'h5A5, 4'h0, "R10");
        pulse_start();
        accept();
        pulse_start();
        repeat (60) @(negedge clk);
        chk(fno == fi, "R10", "frames after ignored starts", fno, fi);
        chk(adc_cs_n == 1'b1, "R9", "cs high during and after quiet", int'(adc_cs_n), 1);

        @(negedge clk);
        cfg_quiet = 8'd1;
        prep(fi, 2'd0, 4'h0, 12'h777, 4'h0);
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        wait_valid("R10");
        check_result(fi, "R10");
        fi++;
        accept();
        repeat (100) @(negedge clk);
        chk(fno == fi, "R10", "start in frame ignored", fno, fi);

        // R8 / R10: backpressure, then accept and launch in one cycle
        do_frame(2'd1, 0, 1, 4'h0, 12'h1C3, 4'h0, "R8");
        begin
            int held = int'(res_data);
            repeat (60) @(negedge clk);
            chk(res_valid == 1'b1 && int'(res_data) == held, "R8", "held result", int'(res_data), held);
        end
        pulse_start();
        repeat (40) @(negedge clk);
        chk(fno == fi && adc_cs_n == 1'b1, "R10", "start with full slot ignored", fno, fi);
        prep(fi, 2'd0, 4'h0, 12'h9D2, 4'h0);
        cfg_res = 2'd0;
        @(negedge clk);
        start = 1'b1; res_ready = 1'b1;
        @(negedge clk);
        start = 1'b0; res_ready = 1'b0;
        chk(res_valid == 1'b0, "R8", "accepted in launch cycle", int'(res_valid), 0);
        repeat (2) @(negedge clk);
        chk(adc_cs_n == 1'b0, "R10", "launch on same-cycle accept", int'(adc_cs_n), 0);
        wait_valid("R10");
        check_result(fi, "R10");
        fi++;
        accept();
        repeat (8) @(negedge clk);

        // R9 / R11: continuous sampling, ready held high
        @(negedge clk);
        cfg_div = 8'd1; cfg_quiet = 8'd5; cfg_res = 2'd0; res_ready = 1'b1;
        for (int k = 0; k < 5; k++)
            prep(fi + k, 2'd0, 4'h0, 12'($urandom), 4'h0);
        cfg_cont = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_valid("R11");
            check_result(fi + k, "R11");
            if (k >= 1) chk(last_hi == 7, "R9", "back-to-back quiet gap", last_hi, 7);
            if (k == 4) cfg_cont = 1'b0;
            @(negedge clk);
        end
        fi += 5;
        res_ready = 1'b0;
        repeat (80) @(negedge clk);
        chk(fno == fi, "R11", "relaunch stops", fno, fi);

        // Constrained random single-shot frames
        for (int n = 0; n < 24; n++) begin
            logic [1:0]  r    = 2'($urandom % 4);
            int          dv   = int'($urandom % 4);
            int          q    = int'($urandom % 8);
            logic [3:0]  lead = ($urandom % 4 == 0) ? 4'(($urandom % 15) + 1) : 4'h0;
            logic [11:0] d    = 12'($urandom);
            logic [3:0]  tr   = 4'($urandom);
            do_frame(r, dv, q, lead, d, tr, "R5");
            accept();
            repeat (q + 4) @(negedge clk);
        end

        chk(idle_bad == 1'b0, "R2", "clock low while deselected", int'(idle_bad), 0);
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule